// File: doc/BRIEF.md
# Big-Endian Load/Store Alignment Unit

This block sits between the load/store stage of a 32-bit processor and a 32-bit data bus. It accepts one access request at a time. Each request carries an address, an access size, a direction, a signed-load flag and store data. From these it produces the bus byte enables and a store word with the data copied onto the right lanes. When a load completes, it picks the addressed bytes out of the returned bus word and widens them to 32 bits, with either zero or sign extension. Lane order is big-endian: byte offset 0 within a word is the most significant lane, bits 31:24.

The unit also checks alignment. A word must sit on a 4-byte boundary and a half-word on a 2-byte boundary. The input `align_trap_en` sets what happens to a misaligned access. When it is high, the access is stopped before it reaches the bus, a one-cycle exception pulse is raised, and two exception registers capture the full faulting address and the kind of fault. When it is low, the address is silently rounded down to its natural boundary and the access goes ahead.

A single state machine controls the sequence. `ST_IDLE` takes a request. It moves to `ST_BUS` for a legal or silently aligned access, and to `ST_TRAP` for a trapped misaligned one. `ST_BUS` holds the bus request until `bus_ack` and then moves to `ST_DONE`. `ST_DONE` presents the response for one cycle and returns to `ST_IDLE`. `ST_TRAP` pulses the exception for one cycle and returns to `ST_IDLE`.

Top module: `be_lsu_align`

## Requirements
- R1: Size codes are 00 byte, 01 half-word, 10 word and 11 word as well. A byte at offset k enables only lane bit (3-k) of `bus_be`, where bit 3 is the bits 31:24 lane. A half-word at offset 0 enables 1100 and one at offset 2 enables 0011. A word enables 1111.
- R2: For a store, `bus_we` is 1. `bus_wdata` carries the low byte of the store data on all four lanes for a byte access, the low half-word on both halves for a half-word access, and the whole word for a word access.
- R3: An unsigned load returns the addressed byte or half-word, shifted down to bit 0 and zero-extended. Offset 0 selects the most significant byte of the bus word. A word load returns the bus word unchanged.
- R4: A byte or half-word load with `req_signed` high is sign-extended from its top bit. For word loads, `req_signed` has no effect.
- R5: With `align_trap_en` high, a misaligned request never raises `bus_valid`. `exc_pulse` is high for exactly the one cycle after the request is accepted.
- R6: On a trap, `exc_addr` captures the full 32-bit request address, and `exc_cause` is set to 01 for a load or 10 for a store. Both keep their values through later non-faulting accesses until the next trap.
- R7: With `align_trap_en` low, a misaligned request goes to the bus with its low address bits cleared to the natural boundary (two bits for a word, one for a half-word). It then behaves as the aligned access, and no exception is raised.
- R8: `req_ready` is high only in the idle state. A request accepted in cycle n drives the bus in cycle n+1. The bus address, enables and data stay stable until the cycle in which `bus_ack` is sampled high. `resp_valid` is high for the single following cycle.
- R9: After reset, `req_ready` is 1; `bus_valid`, `resp_valid` and `exc_pulse` are 0; `exc_addr` and `exc_cause` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| align_trap_en | input | 1 | 1: misaligned accesses trap; 0: they are aligned silently |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Unit idle, request taken this cycle |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | 2 | 00 byte, 01 half-word, 1x word |
| req_store | input | 1 | 1 store, 0 load |
| req_signed | input | 1 | Sign-extend a byte or half-word load |
| req_wdata | input | DATA_W | Store data, right-justified |
| bus_valid | output | 1 | Bus access in progress |
| bus_addr | output | ADDR_W | Effective bus address |
| bus_be | output | DATA_W/8 | Byte enables, bit 3 = bits 31:24 lane |
| bus_we | output | 1 | Bus write |
| bus_wdata | output | DATA_W | Lane-replicated store word |
| bus_rdata | input | DATA_W | Read word from the bus |
| bus_ack | input | 1 | Bus completes the access this cycle |
| resp_valid | output | 1 | Access completed |
| resp_rdata | output | DATA_W | Extended load result, 0 for stores |
| exc_pulse | output | 1 | One-cycle misalignment exception |
| exc_addr | output | ADDR_W | Address of the last trapped access |
| exc_cause | output | 2 | 01 load misaligned, 10 store misaligned |

## Verification
A wrong lane decode or a wrong offset register shows up at once. It gives bad `bus_be` or `bus_wdata` in the first bus cycle of the access. On a load it gives a wrong `resp_rdata` in the cycle after the acknowledge. An exception register that is overwritten by an ordinary access stays invisible until `exc_addr` is compared after that access. The bench therefore re-reads both exception registers after every non-faulting access. Data corruption that lands only in memory appears when a later load reads those bytes back. For that reason the random phase mixes stores and loads over a small 64-byte window.

// File: rtl/be_align_pkg.sv
package be_align_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WALT = 2'b11
    } acc_size_e;

    typedef enum logic [1:0] {
        CAUSE_NONE      = 2'b00,
        CAUSE_LOAD_MIS  = 2'b01,
        CAUSE_STORE_MIS = 2'b10
    } exc_cause_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_BUS,
        ST_DONE,
        ST_TRAP
    } lsu_state_e;

endpackage

// File: rtl/be_align_check.sv
// Alignment test and address rounding for a given access size.
module be_align_check #(
    parameter int ADDR_W = 32,
    parameter int NBYTES = 4,
    localparam int OFF_W = $clog2(NBYTES)
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output logic              misaligned,
    output logic [ADDR_W-1:0] aligned_addr,
    output logic [OFF_W-1:0]  off
);
    import be_align_pkg::*;

    logic [OFF_W-1:0] mask;

    always_comb begin
        unique case (size)
            SZ_BYTE: mask = '0;
            SZ_HALF: mask = OFF_W'(1);
            default: mask = '1;
        endcase
        misaligned   = |(addr[OFF_W-1:0] & mask);
        aligned_addr = {addr[ADDR_W-1:OFF_W], addr[OFF_W-1:0] & ~mask};
        off          = aligned_addr[OFF_W-1:0];
    end
endmodule

// File: rtl/be_lane_steer.sv
// Byte-enable decode and store-lane replication, big-endian lanes.
module be_lane_steer #(
    parameter int NBYTES = 4,
    localparam int OFF_W  = $clog2(NBYTES),
    localparam int DATA_W = NBYTES * 8
) (
    input  logic [1:0]        size,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] wdata,
    output logic [NBYTES-1:0] be,
    output logic [DATA_W-1:0] lanes
);
    import be_align_pkg::*;

    always_comb begin
        unique case (size)
            SZ_BYTE: be = NBYTES'(1) << (OFF_W'(NBYTES - 1) - off);
            SZ_HALF: be = NBYTES'(3) << (OFF_W'(NBYTES - 2) - off);
            default: be = '1;
        endcase
    end

    for (genvar i = 0; i < NBYTES; i++) begin : g_lane
        localparam int HLANE = i % 2;
        always_comb begin
            unique case (size)
                SZ_BYTE: lanes[8*i +: 8] = wdata[7:0];
                SZ_HALF: lanes[8*i +: 8] = wdata[8*HLANE +: 8];
                default: lanes[8*i +: 8] = wdata[8*i +: 8];
            endcase
        end
    end
endmodule

// File: rtl/be_load_extract.sv
// Pick the addressed bytes from a bus word and widen them.
module be_load_extract #(
    parameter int NBYTES = 4,
    localparam int OFF_W  = $clog2(NBYTES),
    localparam int DATA_W = NBYTES * 8
) (
    input  logic [1:0]        size,
    input  logic [OFF_W-1:0]  off,
    input  logic              sext,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] result
);
    import be_align_pkg::*;

    logic [OFF_W-1:0] lane_b;
    logic [OFF_W-1:0] lane_h;
    logic [7:0]       sel_b;
    logic [15:0]      sel_h;

    always_comb begin
        lane_b = OFF_W'(NBYTES - 1) - off;
        lane_h = OFF_W'(NBYTES - 2) - off;
        sel_b  = rdata[{lane_b, 3'b000} +: 8];
        sel_h  = rdata[{lane_h, 3'b000} +: 16];
        unique case (size)
            SZ_BYTE: result = {{(DATA_W-8){sext & sel_b[7]}}, sel_b};
            SZ_HALF: result = {{(DATA_W-16){sext & sel_h[15]}}, sel_h};
            default: result = rdata;
        endcase
    end
endmodule

// File: rtl/be_exc_regs.sv
// Exception address and cause, written only on a trap.
module be_exc_regs #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [ADDR_W-1:0] fault_addr,
    input  logic [1:0]        fault_cause,
    output logic [ADDR_W-1:0] exc_addr,
    output logic [1:0]        exc_cause
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_addr  <= '0;
            exc_cause <= '0;
        end else if (capture) begin
            exc_addr  <= fault_addr;
            exc_cause <= fault_cause;
        end
    end
endmodule

// File: rtl/be_lsu_align.sv
module be_lsu_align #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                align_trap_en,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [1:0]          req_size,
    input  logic                req_store,
    input  logic                req_signed,
    input  logic [DATA_W-1:0]   req_wdata,
    output logic                bus_valid,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [DATA_W/8-1:0] bus_be,
    output logic                bus_we,
    output logic [DATA_W-1:0]   bus_wdata,
    input  logic [DATA_W-1:0]   bus_rdata,
    input  logic                bus_ack,
    output logic                resp_valid,
    output logic [DATA_W-1:0]   resp_rdata,
    output logic                exc_pulse,
    output logic [ADDR_W-1:0]   exc_addr,
    output logic [1:0]          exc_cause
);
    import be_align_pkg::*;

    localparam int NBYTES = DATA_W / 8;
    localparam int OFF_W  = $clog2(NBYTES);

    lsu_state_e state_q, state_d;

    logic              misaligned;
    logic [ADDR_W-1:0] eff_addr;
    logic [OFF_W-1:0]  eff_off;
    logic [NBYTES-1:0] be_c;
    logic [DATA_W-1:0] lanes_c;
    logic [DATA_W-1:0] load_c;

    logic [ADDR_W-1:0] addr_q;
    logic [NBYTES-1:0] be_q;
    logic              we_q;
    logic [DATA_W-1:0] wdata_q;
    logic [1:0]        size_q;
    logic [OFF_W-1:0]  off_q;
    logic              sext_q;
    logic [DATA_W-1:0] rdata_q;

    logic accept;
    logic trap;

    be_align_check #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) u_check (
        .addr         (req_addr),
        .size         (req_size),
        .misaligned   (misaligned),
        .aligned_addr (eff_addr),
        .off          (eff_off)
    );

    be_lane_steer #(.NBYTES(NBYTES)) u_steer (
        .size  (req_size),
        .off   (eff_off),
        .wdata (req_wdata),
        .be    (be_c),
        .lanes (lanes_c)
    );

    be_load_extract #(.NBYTES(NBYTES)) u_extract (
        .size   (size_q),
        .off    (off_q),
        .sext   (sext_q),
        .rdata  (bus_rdata),
        .result (load_c)
    );

    be_exc_regs #(.ADDR_W(ADDR_W)) u_exc (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (trap),
        .fault_addr  (req_addr),
        .fault_cause (req_store ? CAUSE_STORE_MIS : CAUSE_LOAD_MIS),
        .exc_addr    (exc_addr),
        .exc_cause   (exc_cause)
    );

    assign accept = req_valid && (state_q == ST_IDLE);
    assign trap   = accept && misaligned && align_trap_en;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (trap) state_d = ST_TRAP;
                     else if (accept) state_d = ST_BUS;
            ST_BUS:  if (bus_ack) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            ST_TRAP: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // state outputs
    always_comb begin
        req_ready  = 1'b0;
        bus_valid  = 1'b0;
        resp_valid = 1'b0;
        exc_pulse  = 1'b0;
        unique case (state_q)
            ST_IDLE: req_ready  = 1'b1;
            ST_BUS:  bus_valid  = 1'b1;
            ST_DONE: resp_valid = 1'b1;
            ST_TRAP: exc_pulse  = 1'b1;
        endcase
    end

    // request capture and load result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            be_q    <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
            size_q  <= '0;
            off_q   <= '0;
            sext_q  <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (accept && !trap) begin
                addr_q  <= eff_addr;
                be_q    <= be_c;
                we_q    <= req_store;
                wdata_q <= lanes_c;
                size_q  <= req_size;
                off_q   <= eff_off;
                sext_q  <= req_signed;
            end
            if (state_q == ST_BUS && bus_ack)
                rdata_q <= we_q ? '0 : load_c;
        end
    end

    assign bus_addr   = addr_q;
    assign bus_be     = be_q;
    assign bus_we     = we_q;
    assign bus_wdata  = wdata_q;
    assign resp_rdata = rdata_q;

endmodule

// File: rtl/be_lsu_align_chk.sv
module be_lsu_align_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              align_trap_en,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic              bus_valid,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [3:0]        bus_be,
    input logic              bus_ack,
    input logic              resp_valid,
    input logic              exc_pulse,
    input logic [ADDR_W-1:0] exc_addr
);
    logic req_mis;
    assign req_mis = (req_size == 2'b01 && req_addr[0]) ||
                     (req_size[1] && req_addr[1:0] != 2'b00);

    // R1
    a_r1_be_shape: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> ($countones(bus_be) == 1 || $countones(bus_be) == 2 ||
                       $countones(bus_be) == 4));
    a_r1_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_be == 4'b1111) |-> bus_addr[1:0] == 2'b00);
    // R5
    a_r5_trap_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && align_trap_en && req_mis) |=> (exc_pulse && !bus_valid));
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        exc_pulse |=> !exc_pulse);
    // R6
    a_r6_exc_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_addr != $past(exc_addr)) |-> exc_pulse);
    // R7
    a_r7_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !align_trap_en) |=> (bus_valid && !exc_pulse));
    // R8
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && !bus_ack) |=> (bus_valid && $stable(bus_addr) && $stable(bus_be)));
    a_r8_resp: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_ack) |=> (resp_valid && !bus_valid));
endmodule

bind be_lsu_align be_lsu_align_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .align_trap_en (align_trap_en),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_addr      (req_addr),
    .req_size      (req_size),
    .bus_valid     (bus_valid),
    .bus_addr      (bus_addr),
    .bus_be        (bus_be),
    .bus_ack       (bus_ack),
    .resp_valid    (resp_valid),
    .exc_pulse     (exc_pulse),
    .exc_addr      (exc_addr)
);

// File: tb/be_lsu_align_tb.sv
`timescale 1ns/1ps
module be_lsu_align_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        align_trap_en = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic        req_store = 1'b0;
    logic        req_signed = 1'b0;
    logic [31:0] req_wdata = '0;
    logic        bus_valid;
    logic [31:0] bus_addr;
    logic [3:0]  bus_be;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata = '0;
    logic        bus_ack = 1'b0;
    logic        resp_valid;
    logic [31:0] resp_rdata;
    logic        exc_pulse;
    logic [31:0] exc_addr;
    logic [1:0]  exc_cause;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [7:0]  ref_mem [64];
    logic [31:0] bus_mem [16];
    logic [31:0] last_trap_addr = '0;
    logic [1:0]  last_trap_cause = '0;

    always #2.5 clk = ~clk;

    be_lsu_align u_dut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic bit mis_f(logic [1:0] sz, logic [1:0] a);
        if (sz == 2'b00) return 1'b0;
        if (sz == 2'b01) return a[0];
        return a != 2'b00;
    endfunction

    function automatic logic [31:0] ea_f(logic [31:0] a, logic [1:0] sz);
        if (sz == 2'b00) return a;
        if (sz == 2'b01) return {a[31:1], 1'b0};
        return {a[31:2], 2'b00};
    endfunction

    function automatic logic [3:0] be_f(logic [1:0] sz, logic [1:0] off);
        if (sz == 2'b00) return 4'b1000 >> off;
        if (sz == 2'b01) return off[1] ? 4'b0011 : 4'b1100;
        return 4'b1111;
    endfunction

    function automatic logic [31:0] wd_f(logic [1:0] sz, logic [31:0] w);
        if (sz == 2'b00) return {4{w[7:0]}};
        if (sz == 2'b01) return {2{w[15:0]}};
        return w;
    endfunction

    function automatic logic [31:0] rd_f(logic [1:0] sz, bit sg, logic [5:0] a);
        logic [7:0]  b;
        logic [15:0] h;
        b = ref_mem[a];
        h = {ref_mem[a], ref_mem[a + 6'd1]};
        if (sz == 2'b00) return sg ? {{24{b[7]}}, b} : {24'd0, b};
        if (sz == 2'b01) return sg ? {{16{h[15]}}, h} : {16'd0, h};
        return {ref_mem[a], ref_mem[a + 6'd1], ref_mem[a + 6'd2], ref_mem[a + 6'd3]};
    endfunction

    task automatic access(input bit trap, input logic [31:0] addr, input logic [1:0] sz,
                          input bit st, input bit sg, input logic [31:0] wd);
        bit          mis;
        logic [31:0] ea;
        logic [31:0] exp_rd;
        int          dly;
        mis    = mis_f(sz, addr[1:0]);
        ea     = (mis && !trap) ? ea_f(addr, sz) : addr;
        exp_rd = rd_f(sz, sg, ea[5:0]);
        @(negedge clk);
        align_trap_en = trap; req_addr = addr; req_size = sz;
        req_store = st; req_signed = sg; req_wdata = wd; req_valid = 1'b1;
        chk(req_ready == 1'b1, "R8", "ready when idle", {31'd0, req_ready}, 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        if (mis && trap) begin
            chk(exc_pulse == 1'b1, "R5", "exception pulse", {31'd0, exc_pulse}, 32'd1);
            chk(bus_valid == 1'b0, "R5", "no bus on trap", {31'd0, bus_valid}, 32'd0);
            chk(exc_addr == addr, "R6", "exception address", exc_addr, addr);
            chk(exc_cause == (st ? 2'b10 : 2'b01), "R6", "exception cause",
                {30'd0, exc_cause}, st ? 32'd2 : 32'd1);
            last_trap_addr  = addr;
            last_trap_cause = st ? 2'b10 : 2'b01;
            @(negedge clk);
            chk(exc_pulse == 1'b0, "R5", "pulse one cycle", {31'd0, exc_pulse}, 32'd0);
            chk(bus_valid == 1'b0, "R5", "still no bus", {31'd0, bus_valid}, 32'd0);
            return;
        end
        chk(bus_valid == 1'b1, "R8", "bus request next cycle", {31'd0, bus_valid}, 32'd1);
        chk(exc_pulse == 1'b0, "R7", "no exception", {31'd0, exc_pulse}, 32'd0);
        chk(bus_addr == ea, mis ? "R7" : "R1", "bus address", bus_addr, ea);
        chk(bus_be == be_f(sz, ea[1:0]), "R1", "byte enables", {28'd0, bus_be},
            {28'd0, be_f(sz, ea[1:0])});
        chk(bus_we == st, "R2", "write flag", {31'd0, bus_we}, {31'd0, st});
        if (st) chk(bus_wdata == wd_f(sz, wd), "R2", "store lanes", bus_wdata, wd_f(sz, wd));
        dly = $urandom % 3;
        for (int i = 0; i < dly; i++) begin
            @(negedge clk);
            chk(bus_valid == 1'b1 && bus_addr == ea, "R8", "held until ack",
                bus_addr, ea);
        end
        bus_rdata = bus_mem[ea[5:2]];
        bus_ack   = 1'b1;
        if (st) begin
            for (int l = 0; l < 4; l++)
                if (bus_be[l]) bus_mem[ea[5:2]][8*l +: 8] = bus_wdata[8*l +: 8];
        end
        @(negedge clk);
        bus_ack = 1'b0;
        chk(resp_valid == 1'b1, "R8", "response after ack", {31'd0, resp_valid}, 32'd1);
        chk(bus_valid == 1'b0, "R8", "bus released", {31'd0, bus_valid}, 32'd0);
        if (!st) begin
            if (sg && !sz[1]) chk(resp_rdata == exp_rd, "R4", "signed load", resp_rdata, exp_rd);
            else              chk(resp_rdata == exp_rd, "R3", "load data", resp_rdata, exp_rd);
        end else begin
            if (sz == 2'b00) ref_mem[ea[5:0]] = wd[7:0];
            else if (sz == 2'b01) begin
                ref_mem[ea[5:0]]        = wd[15:8];
                ref_mem[ea[5:0] + 6'd1] = wd[7:0];
            end else begin
                ref_mem[ea[5:0]]        = wd[31:24];
                ref_mem[ea[5:0] + 6'd1] = wd[23:16];
                ref_mem[ea[5:0] + 6'd2] = wd[15:8];
                ref_mem[ea[5:0] + 6'd3] = wd[7:0];
            end
        end
        chk(exc_addr == last_trap_addr && exc_cause == last_trap_cause, "R6",
            "exception registers held", exc_addr, last_trap_addr);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 64; i++) ref_mem[i] = 8'(i * 37 + 5);
        for (int w = 0; w < 16; w++)
            bus_mem[w] = {ref_mem[4*w], ref_mem[4*w+1], ref_mem[4*w+2], ref_mem[4*w+3]};
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1 && bus_valid == 1'b0 && resp_valid == 1'b0 && exc_pulse == 1'b0,
            "R9", "reset outputs", {28'd0, req_ready, bus_valid, resp_valid, exc_pulse}, 32'h8);
        chk(exc_addr == 32'd0 && exc_cause == 2'd0, "R9", "reset exception regs",
            exc_addr, 32'd0);
        rst_n = 1'b1;

        // directed sweep: trap mode, size, offset, signedness, direction
        for (int t = 0; t < 2; t++)
            for (int s = 0; s < 4; s++)
                for (int o = 0; o < 4; o++)
                    for (int g = 0; g < 2; g++)
                        for (int d = 0; d < 2; d++)
                            access(bit'(t), {24'hA5_0000, 2'b00, 4'(s * 4 + o), 2'(o)} ^ 32'h0,
                                   2'(s), bit'(d), bit'(g), 32'hF0E1_D2C3 ^ (32'(o) << 4));

        // directed sign corners: negative byte and half-word
        access(1'b1, 32'h0000_0010, 2'b00, 1'b1, 1'b0, 32'h0000_0080);
        access(1'b1, 32'h0000_0010, 2'b00, 1'b0, 1'b1, 32'h0);
        access(1'b1, 32'h0000_0012, 2'b01, 1'b1, 1'b0, 32'h0000_8001);
        access(1'b1, 32'h0000_0012, 2'b01, 1'b0, 1'b1, 32'h0);
        access(1'b1, 32'h0000_0010, 2'b10, 1'b0, 1'b1, 32'h0);

        // random phase
        for (int n = 0; n < 400; n++)
            access(($urandom % 4) != 0, $urandom, 2'($urandom % 4),
                   bit'($urandom % 2), bit'($urandom % 2), $urandom);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule